// File: doc/BRIEF.md
# Random Access Scan Latch Array

This block holds a bank of state bits for a sequential circuit, laid out as a grid of rows and columns. In normal operation, a system update strobe loads every bit from its functional next-state input. For test, any single bit can be picked out, much as a RAM cell is. A row decoder and a column decoder together select exactly one bit. A scan write strobe then stores the scan-in value into that bit alone. The scan-out pin always shows the value of the selected bit.

The selection comes from one of two address sources. In parallel mode, the row and column are taken from dedicated address pins. In serial mode, they come from an internal address counter. That counter is loaded one bit at a time over a two-wire shift port, and it steps forward by one after every scan write. A tester can then walk through the whole array while using only a handful of pins. An active-low reset clears every bit and the counter.

A typical test session runs as follows. Reset the block. Scan each bit in at its address. Give one system update. Read every bit back through scan-out. Every change of state is synchronous to `clk`, apart from the reset.

Top module: `ras_latch_array`

## Requirements
- R1: While `rst_n` is low, every bit of `state_q` and the address counter read 0. This holds at once, whatever the other inputs do.
- R2: In parallel mode (`addr_mode`=0), the selected bit is `state_q[row_addr*COLS + col_addr]`. This equals the bit index `{row_addr, col_addr}`. `func_d` uses the same bit order.
- R3: With `scan_wr`=1 at a rising edge, `scan_in` is stored into the selected bit only. All other bits keep their values.
- R4: `scan_out` shows the selected bit combinationally, in both address modes.
- R5: With `sys_en`=1 and `scan_wr`=0 at an edge, `state_q` takes the value of `func_d`.
- R6: With both `sys_en` and `scan_wr` low at an edge, `state_q` keeps its value.
- R7: With `scan_wr` and `sys_en` both high at the same edge, only the scan write takes place. No bit loads from `func_d`.
- R8: `addr_shift`=1 at an edge shifts the counter left by one and brings `addr_sin` into bit 0. Sending an address MSB first therefore loads it. In serial mode (`addr_mode`=1), the selected bit index equals the counter value: the row is in the upper bits and the column in the lower bits.
- R9: In serial mode, each `scan_wr` adds one to the counter after the write. The counter wraps from ROWS*COLS-1 back to 0. If `addr_shift` occurs at the same edge, the increment wins and the shift is ignored.
- R10: In parallel mode, `scan_wr` does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst_n | input | 1 | Active-low master reset, clears all bits and the counter |
| addr_mode | input | 1 | 0 = parallel address pins, 1 = serial counter |
| row_addr | input | $clog2(ROWS) | Parallel row address (X) |
| col_addr | input | $clog2(COLS) | Parallel column address (Y) |
| addr_shift | input | 1 | Shift strobe for the address counter |
| addr_sin | input | 1 | Serial address bit |
| scan_wr | input | 1 | Scan write strobe |
| scan_in | input | 1 | Scan data bit |
| scan_out | output | 1 | Value of the selected bit |
| sys_en | input | 1 | System update strobe |
| func_d | input | ROWS*COLS | Functional next-state inputs |
| state_q | output | ROWS*COLS | Current state of all bits |

## Verification
The scan write strobe and the system update strobe can fall on the same edge. So can a scan write and an address shift while in serial mode. Directed cases assert each pair together on purpose. The random phase also raises both strobes together about one cycle in nine.

These collisions are judged by a bench model. For the first pair, the model expects every bit except the addressed one to keep its old value, even though `func_d` differs. For the second pair, the model expects the counter to advance by exactly one, with the shifted bit ignored. The counter is observed through `scan_out` in serial mode.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic {
        ADDR_PARALLEL = 1'b0,
        ADDR_SERIAL   = 1'b1
    } addr_src_e;

    typedef enum logic [1:0] {
        CTR_HOLD  = 2'd0,
        CTR_STEP  = 2'd1,
        CTR_SHIFT = 2'd2
    } ctr_op_e;

endpackage

// File: rtl/ras_onehot_dec.sv
module ras_onehot_dec #(
    parameter int unsigned OUTS = 4,
    localparam int unsigned W   = $clog2(OUTS)
) (
    input  logic [W-1:0]    code,
    output logic [OUTS-1:0] onehot
);

    for (genvar i = 0; i < OUTS; i++) begin : g_line
        assign onehot[i] = (code == W'(i));
    end

endmodule

// File: rtl/ras_addr_ctr.sv
module ras_addr_ctr
    import ras_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          shift,
    input  logic          sin,
    output logic [AW-1:0] cnt_q
);

    typedef struct packed {
        logic [AW-1:0] cnt;
    } ctr_t;

    ctr_t    cur_q, nxt_d;
    ctr_op_e op;

    always_comb begin
        nxt_d = cur_q;
        // a step always beats a shift
        if (step)       op = CTR_STEP;
        else if (shift) op = CTR_SHIFT;
        else            op = CTR_HOLD;
        unique case (op)
            CTR_STEP:  nxt_d.cnt = cur_q.cnt + AW'(1);
            CTR_SHIFT: nxt_d.cnt = {cur_q.cnt[AW-2:0], sin};
            default:   nxt_d.cnt = cur_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign cnt_q = cur_q.cnt;

endmodule

// File: rtl/ras_cell_array.sv
module ras_cell_array #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned COLS = 8,
    localparam int unsigned N   = ROWS * COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_oh,
    input  logic [COLS-1:0] col_oh,
    input  logic            scan_wr,
    input  logic            scan_bit,
    input  logic            sys_en,
    input  logic [N-1:0]    func_d,
    output logic [N-1:0]    cell_sel,
    output logic [N-1:0]    state_q
);

    typedef struct packed {
        logic [N-1:0] bits;
    } arr_t;

    arr_t cur_q, nxt_d;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign cell_sel[r*COLS + c] = row_oh[r] & col_oh[c];
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (scan_wr) begin
            nxt_d.bits = (cur_q.bits & ~cell_sel) | (cell_sel & {N{scan_bit}});
        end else if (sys_en) begin
            nxt_d.bits = func_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign state_q = cur_q.bits;

endmodule

// File: rtl/ras_latch_array.sv
module ras_latch_array
    import ras_pkg::*;
#(
    parameter int unsigned ROWS = 4,
    parameter int unsigned COLS = 8,
    localparam int unsigned XW  = $clog2(ROWS),
    localparam int unsigned YW  = $clog2(COLS),
    localparam int unsigned AW  = XW + YW,
    localparam int unsigned N   = ROWS * COLS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_mode,
    input  logic [XW-1:0] row_addr,
    input  logic [YW-1:0] col_addr,
    input  logic          addr_shift,
    input  logic          addr_sin,
    input  logic          scan_wr,
    input  logic          scan_in,
    output logic          scan_out,
    input  logic          sys_en,
    input  logic [N-1:0]  func_d,
    output logic [N-1:0]  state_q
);

    logic            serial;
    logic [AW-1:0]   addr_cnt;
    logic [XW-1:0]   sel_row;
    logic [YW-1:0]   sel_col;
    logic [ROWS-1:0] row_oh;
    logic [COLS-1:0] col_oh;
    logic [N-1:0]    cell_sel;

    assign serial  = (addr_src_e'(addr_mode) == ADDR_SERIAL);
    assign sel_row = serial ? addr_cnt[AW-1:YW] : row_addr;
    assign sel_col = serial ? addr_cnt[YW-1:0]  : col_addr;

    ras_addr_ctr #(.AW(AW)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (serial & scan_wr),
        .shift (addr_shift),
        .sin   (addr_sin),
        .cnt_q (addr_cnt)
    );

    ras_onehot_dec #(.OUTS(ROWS)) u_xdec (.code(sel_row), .onehot(row_oh));
    ras_onehot_dec #(.OUTS(COLS)) u_ydec (.code(sel_col), .onehot(col_oh));

    ras_cell_array #(.ROWS(ROWS), .COLS(COLS)) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_oh   (row_oh),
        .col_oh   (col_oh),
        .scan_wr  (scan_wr),
        .scan_bit (scan_in),
        .sys_en   (sys_en),
        .func_d   (func_d),
        .cell_sel (cell_sel),
        .state_q  (state_q)
    );

    assign scan_out = |(state_q & cell_sel);

endmodule

// File: rtl/ras_latch_array_chk.sv
module ras_latch_array_chk #(
    parameter int unsigned ROWS = 4,
    parameter int unsigned COLS = 8,
    localparam int unsigned XW  = $clog2(ROWS),
    localparam int unsigned YW  = $clog2(COLS),
    localparam int unsigned AW  = XW + YW,
    localparam int unsigned N   = ROWS * COLS
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_mode,
    input logic [XW-1:0] row_addr,
    input logic [YW-1:0] col_addr,
    input logic          addr_shift,
    input logic          addr_sin,
    input logic          scan_wr,
    input logic          scan_in,
    input logic          scan_out,
    input logic          sys_en,
    input logic [N-1:0]  func_d,
    input logic [N-1:0]  state_q,
    input logic [AW-1:0] addr_cnt
);

    logic [AW-1:0] eidx;
    logic [N-1:0]  emask;

    assign eidx  = addr_mode ? addr_cnt : {row_addr, col_addr};
    assign emask = N'(1) << eidx;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0 && addr_cnt == '0));

    // R3
    scan_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_wr |=> state_q[$past(eidx)] == $past(scan_in));

    // R7
    scan_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_wr |=> ((state_q ^ $past(state_q)) & ~$past(emask)) == '0);

    // R4
    scan_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out == state_q[eidx]);

    // R5
    sys_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_en && !scan_wr) |=> state_q == $past(func_d));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_en && !scan_wr) |=> $stable(state_q));

    // R9
    ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_mode && scan_wr) |=> addr_cnt == AW'($past(addr_cnt) + AW'(1)));

    // R8
    ctr_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_shift && !(addr_mode && scan_wr)) |=>
            addr_cnt == {$past(addr_cnt[AW-2:0]), $past(addr_sin)});

    // R10
    ctr_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_mode && !addr_shift) |=> $stable(addr_cnt));

endmodule

bind ras_latch_array ras_latch_array_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_mode  (addr_mode),
    .row_addr   (row_addr),
    .col_addr   (col_addr),
    .addr_shift (addr_shift),
    .addr_sin   (addr_sin),
    .scan_wr    (scan_wr),
    .scan_in    (scan_in),
    .scan_out   (scan_out),
    .sys_en     (sys_en),
    .func_d     (func_d),
    .state_q    (state_q),
    .addr_cnt   (addr_cnt)
);

// File: tb/sim_ras_latch_array.sv
`timescale 1ns/1ps
module sim_ras_latch_array;

    localparam int ROWS = 4;
    localparam int COLS = 8;
    localparam int XW   = 2;
    localparam int YW   = 3;
    localparam int AW   = 5;
    localparam int N    = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_mode = 1'b0;
    logic [XW-1:0] row_addr = '0;
    logic [YW-1:0] col_addr = '0;
    logic          addr_shift = 1'b0;
    logic          addr_sin = 1'b0;
    logic          scan_wr = 1'b0;
    logic          scan_in = 1'b0;
    logic          scan_out;
    logic          sys_en = 1'b0;
    logic [N-1:0]  func_d = '0;
    logic [N-1:0]  state_q;

    int n_chk = 0;
    int n_bad = 0;
    logic [N-1:0]  m_state = '0;
    logic [AW-1:0] m_cnt = '0;

    always #4 clk = ~clk;

    ras_latch_array #(.ROWS(ROWS), .COLS(COLS)) u0 (.*);

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] sel_index(input logic m, input logic [XW-1:0] r,
                                                 input logic [YW-1:0] c, input logic [AW-1:0] cnt);
        return m ? cnt : {r, c};
    endfunction

    // one clock: drive after a falling edge, check scan_out, then state after the edge
    task automatic cyc(input logic m, input logic sc, input logic si, input logic sy,
                       input logic sh, input logic sb, input logic [XW-1:0] r,
                       input logic [YW-1:0] c, input logic [N-1:0] fd, input string tag);
        logic [AW-1:0] ix;
        addr_mode = m; scan_wr = sc; scan_in = si; sys_en = sy;
        addr_shift = sh; addr_sin = sb; row_addr = r; col_addr = c; func_d = fd;
        #1;
        ix = sel_index(m, r, c, m_cnt);
        chk("R4 scan_out", N'(scan_out), N'(m_state[ix]));
        @(posedge clk);
        if (sc)      m_state[ix] = si;
        else if (sy) m_state = fd;
        if (m && sc)  m_cnt = m_cnt + AW'(1);
        else if (sh)  m_cnt = {m_cnt[AW-2:0], sb};
        @(negedge clk);
        chk(tag, state_q, m_state);
        scan_wr = 1'b0; sys_en = 1'b0; addr_shift = 1'b0;
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        for (int i = AW-1; i >= 0; i--)
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, a[i], '0, '0, '0, "R8 shift");
    endtask

    initial begin
        #(8*200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk("R1 reset", state_q, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3: parallel write at row 0 col 5 (bit 5), then row 3 col 7 (bit 31)
        cyc(0, 1, 1, 0, 0, 0, 2'd0, 3'd5, '0, "R3 write");
        chk("R2 bit5", N'(state_q[5]), N'(1));
        cyc(0, 1, 1, 0, 0, 0, 2'd3, 3'd7, '0, "R3 write");
        chk("R2 bit31", N'(state_q[31]), N'(1));
        cyc(0, 1, 0, 0, 0, 0, 2'd0, 3'd5, '0, "R3 clear");
        // R5 / R6
        cyc(0, 0, 0, 1, 0, 0, 2'd1, 3'd2, 32'hA5C3_0F96, "R5 load");
        cyc(0, 0, 0, 0, 0, 0, 2'd1, 3'd2, 32'h1234_5678, "R6 hold");
        // R7: collision, func_d all ones, scan writes 0 into bit 10
        cyc(0, 1, 0, 1, 0, 0, 2'd1, 3'd2, 32'hFFFF_FFFF, "R7 collide");
        chk("R7 untouched", state_q & ~(N'(1) << 10), 32'hA5C3_0F96 & ~(N'(1) << 10));

        // R8 / R9: serial walk across wrap
        load_addr(5'd30);
        cyc(1, 0, 0, 0, 0, 0, '0, '0, '0, "R8 view");
        cyc(1, 1, 1, 0, 0, 0, '0, '0, '0, "R9 w30");
        cyc(1, 1, 0, 0, 0, 0, '0, '0, '0, "R9 w31");
        cyc(1, 1, 1, 0, 1, 1, '0, '0, '0, "R9 wrap+shift");
        chk("R9 counter", N'(m_cnt), N'(1));
        chk("R9 bit0", N'(state_q[0]), N'(1));
        // R10: parallel write leaves the counter alone
        cyc(0, 1, 1, 0, 0, 0, 2'd2, 3'd6, '0, "R10 par write");
        cyc(1, 0, 0, 0, 0, 0, '0, '0, '0, "R10 view");
        cyc(1, 1, 1, 0, 0, 0, '0, '0, '0, "R10 step");
        chk("R10 bit1", N'(state_q[1]), N'(1));

        // R1: reset in mid-run
        rst_n = 1'b0;
        #1;
        chk("R1 mid reset", state_q, '0);
        m_state = '0; m_cnt = '0;
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 0, 0, 0, 0, 0, '0, '0, '0, "R1 counter view");

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic m, sc, sy, sh;
            string tg;
            m  = 1'($urandom % 2);
            sc = ($urandom % 3) == 0;
            sy = ($urandom % 3) == 0;
            sh = ($urandom % 4) == 0;
            if (sc && sy)    tg = "R7 rand";
            else if (m && sc) tg = "R9 rand";
            else if (sc)     tg = "R3 rand";
            else if (sy)     tg = "R5 rand";
            else if (sh)     tg = "R8 rand";
            else             tg = "R6 rand";
            cyc(m, sc, 1'($urandom), sy, sh, 1'($urandom), XW'($urandom), YW'($urandom),
                N'($urandom), tg);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule